// File: doc/BRIEF.md
# Program Start Address Validator

Before a programmable coprocessor is allowed to begin fetching, something must decide whether the requested start location is a legal place to execute from. This block makes that decision. It takes the program bank, the 16-bit program counter, the state of the on-chip instruction cache window, and the two bus-ownership enables: one for the work RAM and one for the program ROM. It returns a yes/no verdict. When it refuses, it also returns a 32-bit word that identifies the offending location.

The classification itself is pure combinational logic. It runs in this order:

- A location inside an active cache window always passes.
- Otherwise, three bank ranges are unused and never pass.
- Otherwise, four banks are work RAM. They pass only while the RAM enable is set.
- Everything else is ROM. It passes only while the ROM enable is set.

The controller pulses a start request together with the operands. One cycle later the block raises a one-cycle done strobe. The verdict and the rejection word are registered, and they hold until the next request.

Top module: `start_addr_check`

## Requirements
- R1: One cycle after a clock edge that samples `start_req` high, `done` is high for exactly one cycle. `start_ok` and `bad_addr` change only on a request edge and otherwise keep their last value.
- R2: When `cache_on` is 1 and `pc` lies in `cache_base` through `cache_base`+511, the result is accepted whatever the bank and the enables. The window is compared in 17 bits and does not wrap past 0xFFFF.
- R3: Outside the cache window, a bank below 0x40 with `pc` below 0x8000 is rejected. A bank below 0x40 with `pc` at or above 0x8000 counts as ROM.
- R4: Outside the cache window, banks 0x60 to 0x6F are rejected.
- R5: Outside the cache window, banks 0x74 to 0xFF are rejected.
- R6: Outside the cache window, banks 0x70 to 0x73 are accepted if and only if `ram_en` is 1.
- R7: Outside the cache window, every other bank (0x40 to 0x5F, and 0x00 to 0x3F with `pc` at or above 0x8000) is accepted if and only if `rom_en` is 1.
- R8: On rejection, `bad_addr` carries the bank in bits 31:24, zero in bits 23:16 and `pc` in bits 15:0. On acceptance, `bad_addr` is all zero.
- R9: While and after reset, before any request, `done`, `start_ok` and `bad_addr` are all zero.
- R10: When `cache_on` is 0, the cache window has no effect: a `pc` inside the window is judged by its bank alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request to evaluate the operands |
| bank | input | 8 | Program bank of the start location |
| pc | input | 16 | Program counter of the start location |
| cache_on | input | 1 | Instruction cache window is active |
| cache_base | input | 16 | First address of the cache window |
| ram_en | input | 1 | Coprocessor owns the work RAM bus |
| rom_en | input | 1 | Coprocessor owns the program ROM bus |
| done | output | 1 | Verdict valid strobe, one cycle after the request |
| start_ok | output | 1 | Start location is legal |
| bad_addr | output | 32 | Rejection word, zero when accepted |

## Verification
The assertions assume that the operands are stable and meaningful only in the cycle that `start_req` is high. They also assume that nothing but a request edge may alter the held verdict, so they compare `start_ok` and `bad_addr` against the operands sampled one cycle earlier. The stimulus drives a request for one cycle and then scrambles every operand while the request stays low, which exercises the hold behaviour. Random banks are steered toward the range edges 0x3F/0x40, 0x5F/0x60, 0x6F/0x70 and 0x73/0x74. Program counters are steered to the 0x8000 split and to the first and last bytes around the cache window.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic [2:0] {
    RG_ROM       = 3'd0,
    RG_RAM       = 3'd1,
    RG_HOLE_LOW  = 3'd2,
    RG_HOLE_MID  = 3'd3,
    RG_HOLE_HIGH = 3'd4
  } region_e;
endpackage

// File: rtl/sac_region_decode.sv
module sac_region_decode
  import sac_pkg::*;
#(
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned LOW_LIMIT = 'h40,
  parameter int unsigned PC_SPLIT  = 'h8000,
  parameter int unsigned MID_LO    = 'h60,
  parameter int unsigned MID_HI    = 'h6F,
  parameter int unsigned RAM_LO    = 'h70,
  parameter int unsigned RAM_HI    = 'h73
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [PC_W-1:0]   pc,
  output region_e           region
);
  localparam logic [BANK_W-1:0] LOW_B   = BANK_W'(LOW_LIMIT);
  localparam logic [BANK_W-1:0] MIDLO_B = BANK_W'(MID_LO);
  localparam logic [BANK_W-1:0] MIDHI_B = BANK_W'(MID_HI);
  localparam logic [BANK_W-1:0] RAMLO_B = BANK_W'(RAM_LO);
  localparam logic [BANK_W-1:0] RAMHI_B = BANK_W'(RAM_HI);
  localparam logic [PC_W-1:0]   SPLIT_P = PC_W'(PC_SPLIT);

  logic low_bank, low_pc, mid_hit, ram_hit, high_hit;

  always_comb begin
    low_bank = (bank < LOW_B);
    low_pc   = (pc < SPLIT_P);
    mid_hit  = (bank >= MIDLO_B) && (bank <= MIDHI_B);
    ram_hit  = (bank >= RAMLO_B) && (bank <= RAMHI_B);
    high_hit = (bank > RAMHI_B);
  end

  // Priority follows the order of the checks: holes first, then RAM, then ROM.
  always_comb begin
    if (low_bank && low_pc) region = RG_HOLE_LOW;
    else if (mid_hit)       region = RG_HOLE_MID;
    else if (high_hit)      region = RG_HOLE_HIGH;
    else if (ram_hit)       region = RG_RAM;
    else                    region = RG_ROM;
  end
endmodule

// File: rtl/sac_cache_window.sv
module sac_cache_window #(
  parameter int unsigned PC_W      = 16,
  parameter int unsigned WIN_BYTES = 512
) (
  input  logic            cache_on,
  input  logic [PC_W-1:0] cache_base,
  input  logic [PC_W-1:0] pc,
  output logic            hit
);
  localparam int unsigned EXT_W = PC_W + 1;
  localparam logic [EXT_W-1:0] WIN_E = EXT_W'(WIN_BYTES);

  logic [EXT_W-1:0] lo_e, hi_e, pc_e;

  // The window end is computed one bit wider, so it never wraps.
  always_comb begin
    lo_e = {1'b0, cache_base};
    hi_e = lo_e + WIN_E;
    pc_e = {1'b0, pc};
    hit  = cache_on && (pc_e >= lo_e) && (pc_e < hi_e);
  end
endmodule

// File: rtl/sac_verdict.sv
module sac_verdict
  import sac_pkg::*;
#(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned WORD_W = 32
) (
  input  region_e           region,
  input  logic              cache_hit,
  input  logic              ram_en,
  input  logic              rom_en,
  input  logic [BANK_W-1:0] bank,
  input  logic [PC_W-1:0]   pc,
  output logic              ok,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned PAD_W = WORD_W - BANK_W - PC_W;

  logic [WORD_W-1:0] packed_loc;

  generate
    if (PAD_W > 0) begin : g_pad
      assign packed_loc = {bank, {PAD_W{1'b0}}, pc};
    end else begin : g_nopad
      assign packed_loc = {bank, pc};
    end
  endgenerate

  always_comb begin
    if (cache_hit) begin
      ok = 1'b1;
    end else begin
      unique case (region)
        RG_RAM:  ok = ram_en;
        RG_ROM:  ok = rom_en;
        default: ok = 1'b0;
      endcase
    end
    word = ok ? '0 : packed_loc;
  end
endmodule

// File: rtl/start_addr_check.sv
module start_addr_check
  import sac_pkg::*;
#(
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned WIN_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [BANK_W-1:0] bank,
  input  logic [PC_W-1:0]   pc,
  input  logic              cache_on,
  input  logic [PC_W-1:0]   cache_base,
  input  logic              ram_en,
  input  logic              rom_en,
  output logic              done,
  output logic              start_ok,
  output logic [WORD_W-1:0] bad_addr
);
  region_e           region;
  logic              cache_hit;
  logic              ok_c;
  logic [WORD_W-1:0] word_c;

  logic              done_d, done_q;
  logic              ok_d, ok_q;
  logic [WORD_W-1:0] word_d, word_q;

  sac_region_decode #(.BANK_W(BANK_W), .PC_W(PC_W)) u_region (
    .bank   (bank),
    .pc     (pc),
    .region (region)
  );

  sac_cache_window #(.PC_W(PC_W), .WIN_BYTES(WIN_BYTES)) u_window (
    .cache_on   (cache_on),
    .cache_base (cache_base),
    .pc         (pc),
    .hit        (cache_hit)
  );

  sac_verdict #(.BANK_W(BANK_W), .PC_W(PC_W), .WORD_W(WORD_W)) u_verdict (
    .region    (region),
    .cache_hit (cache_hit),
    .ram_en    (ram_en),
    .rom_en    (rom_en),
    .bank      (bank),
    .pc        (pc),
    .ok        (ok_c),
    .word      (word_c)
  );

  // Next state: the result registers load only on a request.
  always_comb begin
    done_d = start_req;
    ok_d   = ok_q;
    word_d = word_q;
    if (start_req) begin
      ok_d   = ok_c;
      word_d = word_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      word_q <= '0;
    end else begin
      done_q <= done_d;
      ok_q   <= ok_d;
      word_q <= word_d;
    end
  end

  assign done     = done_q;
  assign start_ok = ok_q;
  assign bad_addr = word_q;
endmodule

// File: rtl/start_addr_check_sva.sv
module start_addr_check_sva #(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_req,
  input logic [BANK_W-1:0] bank,
  input logic [PC_W-1:0]   pc,
  input logic              cache_on,
  input logic [PC_W-1:0]   cache_base,
  input logic              ram_en,
  input logic              rom_en,
  input logic              done,
  input logic              start_ok,
  input logic [WORD_W-1:0] bad_addr
);
  logic in_win;
  assign in_win = cache_on && ({1'b0, pc} >= {1'b0, cache_base}) &&
                  ({1'b0, pc} < ({1'b0, cache_base} + (PC_W+1)'(512)));

  p_done_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> done);
  p_no_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_req |=> !done);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_req |=> ($stable(start_ok) && $stable(bad_addr)));
  p_cache_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && in_win) |=> start_ok);
  p_mid_hole_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !in_win && bank >= 8'h60 && bank <= 8'h6F) |=> !start_ok);
  p_high_hole_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !in_win && bank >= 8'h74) |=> !start_ok);
  p_ram_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !in_win && bank >= 8'h70 && bank <= 8'h73) |=> (start_ok == $past(ram_en)));
  p_rom_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !in_win && bank >= 8'h40 && bank <= 8'h5F) |=> (start_ok == $past(rom_en)));
  p_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_ok) |-> (bad_addr[23:16] == 8'h00));
  p_word_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (start_ok ? (bad_addr == '0)
                            : (bad_addr[31:24] == $past(bank) && bad_addr[15:0] == $past(pc))));
endmodule

bind start_addr_check start_addr_check_sva #(
  .BANK_W(BANK_W), .PC_W(PC_W), .WORD_W(WORD_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .bank(bank), .pc(pc),
  .cache_on(cache_on), .cache_base(cache_base), .ram_en(ram_en), .rom_en(rom_en),
  .done(done), .start_ok(start_ok), .bad_addr(bad_addr)
);

// File: tb/sim_start_addr_check.sv
`timescale 1ns/1ps
module sim_start_addr_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic [7:0]  bank = '0;
  logic [15:0] pc = '0;
  logic        cache_on = 1'b0;
  logic [15:0] cache_base = '0;
  logic        ram_en = 1'b0;
  logic        rom_en = 1'b0;
  logic        done;
  logic        start_ok;
  logic [31:0] bad_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  start_addr_check u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .bank(bank), .pc(pc),
    .cache_on(cache_on), .cache_base(cache_base), .ram_en(ram_en), .rom_en(rom_en),
    .done(done), .start_ok(start_ok), .bad_addr(bad_addr)
  );

  function automatic bit model_hit(input bit con, input int b, input int p);
    return con && (p >= b) && (p < b + 512);
  endfunction

  function automatic string model_tag(input bit con, input int bs, input int bk, input int p);
    if (model_hit(con, bs, p))     return "R2";
    if (bk < 'h40 && p < 'h8000)   return "R3";
    if (bk >= 'h60 && bk <= 'h6F)  return "R4";
    if (bk >= 'h74)                return "R5";
    if (bk >= 'h70)                return "R6";
    return "R7";
  endfunction

  function automatic bit model_ok(input bit con, input int bs, input int bk,
                                  input int p, input bit ram, input bit rom);
    string t;
    t = model_tag(con, bs, bk, p);
    if (t == "R2") return 1'b1;
    if (t == "R6") return ram;
    if (t == "R7") return rom;
    return 1'b0;
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic scramble();
    bank       = 8'($urandom);
    pc         = 16'($urandom);
    cache_on   = 1'($urandom);
    cache_base = 16'($urandom);
    ram_en     = 1'($urandom);
    rom_en     = 1'($urandom);
  endtask

  task automatic run_one(input logic [7:0] b, input logic [15:0] p, input bit con,
                         input logic [15:0] bs, input bit ram, input bit rom);
    bit          e_ok;
    logic [31:0] e_word;
    string       tag;
    @(negedge clk);
    bank = b; pc = p; cache_on = con; cache_base = bs; ram_en = ram; rom_en = rom;
    start_req = 1'b1;
    e_ok   = model_ok(con, int'(bs), int'(b), int'(p), ram, rom);
    tag    = model_tag(con, int'(bs), int'(b), int'(p));
    // R10: with the cache off, the bank-based tag is the only rule in force
    if (!con) tag = {tag, "/R10"};
    e_word = e_ok ? 32'h0 : {b, 8'h00, p};
    @(negedge clk);
    start_req = 1'b0;
    check(done === 1'b1, "R1", "done strobe", longint'(done), 1);
    check(start_ok === e_ok, tag, "start_ok", longint'(start_ok), longint'(e_ok));
    check(bad_addr === e_word, "R8", "bad_addr", longint'(bad_addr), longint'(e_word));
    scramble();
    @(negedge clk);
    check(done === 1'b0, "R1", "done low after strobe", longint'(done), 0);
    check(start_ok === e_ok && bad_addr === e_word, "R1", "held result",
          longint'({31'b0, start_ok}), longint'(e_ok));
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5AC0_1234);
    repeat (3) @(negedge clk);
    check(done === 1'b0 && start_ok === 1'b0 && bad_addr === 32'h0, "R9", "reset state",
          longint'(bad_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0 && start_ok === 1'b0 && bad_addr === 32'h0, "R9", "idle after reset",
          longint'(bad_addr), 0);

    // Directed corners
    run_one(8'h3F, 16'h7FFF, 0, 16'h0, 1, 1);   // R3 rejected
    run_one(8'h3F, 16'h8000, 0, 16'h0, 1, 1);   // R7 ROM above split
    run_one(8'h00, 16'h8000, 0, 16'h0, 1, 0);   // R7 ROM not owned
    run_one(8'h40, 16'h0000, 0, 16'h0, 0, 1);   // R7 ROM any pc
    run_one(8'h5F, 16'h1234, 0, 16'h0, 1, 0);   // R7
    run_one(8'h60, 16'h9000, 0, 16'h0, 1, 1);   // R4
    run_one(8'h6F, 16'hFFFF, 0, 16'h0, 1, 1);   // R4
    run_one(8'h70, 16'h0100, 0, 16'h0, 1, 0);   // R6 owned
    run_one(8'h73, 16'h0100, 0, 16'h0, 0, 1);   // R6 not owned
    run_one(8'h74, 16'h8000, 0, 16'h0, 1, 1);   // R5
    run_one(8'hFF, 16'hFFFF, 0, 16'h0, 1, 1);   // R5
    run_one(8'h65, 16'h2000, 1, 16'h2000, 0, 0); // R2 first byte
    run_one(8'h80, 16'h21FF, 1, 16'h2000, 0, 0); // R2 last byte
    run_one(8'h80, 16'h2200, 1, 16'h2000, 1, 1); // R5 just past window
    run_one(8'h10, 16'h1FFF, 1, 16'h2000, 1, 1); // R3 just before window
    run_one(8'h65, 16'h2000, 0, 16'h2000, 1, 1); // R10 window ignored
    run_one(8'h10, 16'h0005, 1, 16'hFF00, 1, 1); // R2 no wrap past 0xFFFF
    run_one(8'h10, 16'hFFFF, 1, 16'hFF00, 0, 0); // R2 top of space

    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  b;
      logic [15:0] p, bs;
      int          sel;
      bs  = 16'($urandom);
      sel = int'($urandom % 5);
      case (sel)
        0: b = 8'h3E + 8'($urandom % 4);
        1: b = 8'h5E + 8'($urandom % 4);
        2: b = 8'h6E + 8'($urandom % 8);
        default: b = 8'($urandom);
      endcase
      sel = int'($urandom % 4);
      case (sel)
        0: p = 16'h7FFE + 16'($urandom % 4);
        1: p = bs + 16'($urandom % 4) - 16'd2;
        2: p = bs + 16'd510 + 16'($urandom % 4);
        default: p = 16'($urandom);
      endcase
      run_one(b, p, 1'($urandom), bs, 1'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule